// File: doc/BRIEF.md
# Relaxed-Inclusion Shared Cache Tag Controller

This block models the tag side of a set-associative last-level cache shared by several cores. Each accepted lookup names a line address, the requesting core and a page attribute from the address translation. The controller answers hit or miss one cycle later and echoes the requesting core. On a miss it allocates a way in the indexed set. Normally the cache is inclusive. When a valid line is displaced, the private caches must drop their copies, so the controller raises a back-invalidate carrying the displaced line address. Lines whose page is read-only or thread-private carry a per-line relaxed flag. Such a line is dropped silently on eviction. A victim's own private copies therefore survive another core's pressure on the shared cache.

A flush request invalidates a matching line. When that line is relaxed, the controller also raises a write-back-required pulse with the line address. This models the write-back of private modified data that a thread migration needs. Data storage, memory traffic and the coherence protocol are outside the block.

Top module: `ric_llc_ctrl`

## Requirements
- R1: After reset every way is invalid and no output pulse is active. The first lookup to any address reports a miss, and `req_ready_o` is 1.
- R2: A lookup is accepted on a clock edge where `req_valid_i`, `req_ready_o` are 1 and `req_op_i` is 0. In the following cycle only, `resp_valid_o` is 1, `resp_hit_o` gives the hit status and `resp_core_o` equals the accepted `req_core_i`. A flush (`req_op_i` = 1) gives no response.
- R3: A lookup that misses fills a way with the line's tag. The way's relaxed flag is copied from `req_relaxed_i` of that lookup.
- R4: A fill uses the lowest-numbered invalid way of the set whenever one exists. A fill into an invalid way never produces a back-invalidate.
- R5: When all ways of the set are valid, the victim is the least recently used way. Both hits and fills count as uses; flushes do not.
- R6: Evicting a valid line whose relaxed flag is 0 sets `binv_valid_o` in the cycle after the lookup. `binv_line_o` then equals that line's full address: its tag in the upper bits and the set index in the low log2(NUM_SETS) bits.
- R7: Evicting a valid line whose relaxed flag is 1 produces no back-invalidate.
- R8: `binv_valid_o` and `binv_line_o` stay unchanged until a cycle with `binv_ready_i` = 1. They drop after that edge. While `binv_valid_o` is 1, `req_ready_o` is 0 and no request is accepted.
- R9: A hit does not change the line's relaxed flag, whatever `req_relaxed_i` the hitting lookup carries.
- R10: A flush that matches a relaxed line invalidates it. In the next cycle `wb_valid_o` is 1 for one cycle and `wb_line_o` equals the flushed address.
- R11: A flush that matches a normal line invalidates it without a write-back pulse. A flush that matches nothing changes no state and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 1 | 0 lookup, 1 flush |
| req_line_i | input | LINE_W | Line address: tag above, set index in low bits |
| req_core_i | input | CORE_W | Requesting core |
| req_relaxed_i | input | 1 | Page attribute: 1 read-only or thread-private |
| resp_valid_o | output | 1 | Lookup result valid |
| resp_hit_o | output | 1 | Lookup hit |
| resp_core_o | output | CORE_W | Core of the answered lookup |
| binv_valid_o | output | 1 | Back-invalidate request to all private caches |
| binv_ready_i | input | 1 | Back-invalidate taken |
| binv_line_o | output | LINE_W | Address to invalidate |
| wb_valid_o | output | 1 | Write-back-required pulse |
| wb_line_o | output | LINE_W | Address needing private write-back |

## Verification
The hardest situation to reach is a full set whose recency order has been changed by hits. The eviction order then mixes relaxed and normal victims. One of those victims should also have been hit with a contradicting page attribute. The bench fills one set to its associativity with alternating relaxed and normal lines and touches the oldest normal line with the relaxed attribute set. It then pushes a second full set's worth of new tags through. This checks that back-invalidates appear only for normal victims, in recency order, and that the touched line still raises one. During the first back-invalidate the bench holds the ready low to exercise the stall. A long random phase on four narrow sets then mixes flushes with a toggling ready.

// File: rtl/ric_pkg.sv
package ric_pkg;
  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_FLUSH  = 1'b1
  } ric_op_e;
endpackage

// File: rtl/ric_tag_match.sv
module ric_tag_match #(
  parameter int unsigned NUM_WAYS = 16,
  parameter int unsigned TAG_W    = 16,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]       valid_i,
  input  logic [NUM_WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]          tag_i,
  output logic                      hit_o,
  output logic [WAY_W-1:0]          way_o
);
  logic [NUM_WAYS-1:0] eq;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (eq[w]) way_o = WAY_W'(w);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/ric_victim_sel.sv
module ric_victim_sel #(
  parameter int unsigned NUM_WAYS = 16,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]       valid_i,
  input  logic [NUM_WAYS*WAY_W-1:0] ages_i,
  output logic [WAY_W-1:0]          way_o,
  output logic                      occupied_o
);
  logic [WAY_W-1:0] free_way, old_way;
  logic             any_free;

  always_comb begin
    free_way = '0;
    any_free = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) begin
        free_way = WAY_W'(w);
        any_free = 1'b1;
      end
  end

  // ages form a permutation; the oldest way carries the top value
  always_comb begin
    old_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (ages_i[w*WAY_W +: WAY_W] == WAY_W'(NUM_WAYS - 1)) old_way = WAY_W'(w);
  end

  assign way_o      = any_free ? free_way : old_way;
  assign occupied_o = !any_free;
endmodule

// File: rtl/ric_lru_ages.sv
module ric_lru_ages #(
  parameter int unsigned NUM_WAYS = 16,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS*WAY_W-1:0] ages_i,
  input  logic [WAY_W-1:0]          touch_i,
  output logic [NUM_WAYS*WAY_W-1:0] ages_o
);
  logic [WAY_W-1:0] touch_age;

  always_comb begin
    touch_age = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (touch_i == WAY_W'(w)) touch_age = ages_i[w*WAY_W +: WAY_W];
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_age
    logic [WAY_W-1:0] cur;
    assign cur = ages_i[w*WAY_W +: WAY_W];
    assign ages_o[w*WAY_W +: WAY_W] =
        (touch_i == WAY_W'(w)) ? '0 :
        (cur < touch_age)      ? cur + 1'b1 : cur;
  end
endmodule

// File: rtl/ric_llc_ctrl.sv
module ric_llc_ctrl #(
  parameter int unsigned NUM_SETS  = 16,
  parameter int unsigned NUM_WAYS  = 16,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned LINE_W    = 20,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_op_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic              req_relaxed_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [CORE_W-1:0] resp_core_o,
  output logic              binv_valid_o,
  input  logic              binv_ready_i,
  output logic [LINE_W-1:0] binv_line_o,
  output logic              wb_valid_o,
  output logic [LINE_W-1:0] wb_line_o
);
  import ric_pkg::*;

  localparam int unsigned SET_W = $clog2(NUM_SETS);
  localparam int unsigned WAY_W = $clog2(NUM_WAYS);
  localparam int unsigned TAG_W = LINE_W - SET_W;

  logic             valid_q [NUM_SETS][NUM_WAYS];
  logic             rlx_q   [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0] tag_q   [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] age_q   [NUM_SETS][NUM_WAYS];

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  assign set_idx = req_line_i[SET_W-1:0];
  assign req_tag = req_line_i[LINE_W-1:SET_W];

  logic [NUM_WAYS-1:0]       set_valid;
  logic [NUM_WAYS*TAG_W-1:0] set_tags;
  logic [NUM_WAYS*WAY_W-1:0] set_ages, next_ages;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      set_valid[w]                = valid_q[set_idx][w];
      set_tags[w*TAG_W +: TAG_W]  = tag_q[set_idx][w];
      set_ages[w*WAY_W +: WAY_W]  = age_q[set_idx][w];
    end
  end

  logic             hit, vic_occupied;
  logic [WAY_W-1:0] hit_way, vic_way, use_way;

  ric_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i(set_valid), .tags_i(set_tags), .tag_i(req_tag),
    .hit_o(hit), .way_o(hit_way)
  );

  ric_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_victim (
    .valid_i(set_valid), .ages_i(set_ages),
    .way_o(vic_way), .occupied_o(vic_occupied)
  );

  assign use_way = hit ? hit_way : vic_way;

  ric_lru_ages #(.NUM_WAYS(NUM_WAYS)) u_lru (
    .ages_i(set_ages), .touch_i(use_way), .ages_o(next_ages)
  );

  logic accept, do_lookup, do_fill, flush_hit, binv_fire, wb_fire;
  assign accept    = req_valid_i && req_ready_o;
  assign do_lookup = accept && (req_op_i == OP_LOOKUP);
  assign do_fill   = do_lookup && !hit;
  assign flush_hit = accept && (req_op_i == OP_FLUSH) && hit;
  assign binv_fire = do_fill && vic_occupied && !rlx_q[set_idx][vic_way];
  assign wb_fire   = flush_hit && rlx_q[set_idx][hit_way];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          rlx_q[s][w]   <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_W'(w);
        end
    end else begin
      if (do_lookup)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[set_idx][w] <= next_ages[w*WAY_W +: WAY_W];
      if (do_fill) begin
        valid_q[set_idx][vic_way] <= 1'b1;
        tag_q[set_idx][vic_way]   <= req_tag;
        rlx_q[set_idx][vic_way]   <= req_relaxed_i;
      end
      if (flush_hit) valid_q[set_idx][hit_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_core_o  <= '0;
      binv_valid_o <= 1'b0;
      binv_line_o  <= '0;
      wb_valid_o   <= 1'b0;
      wb_line_o    <= '0;
    end else begin
      resp_valid_o <= do_lookup;
      if (do_lookup) begin
        resp_hit_o  <= hit;
        resp_core_o <= req_core_i;
      end
      if (binv_fire) begin
        binv_valid_o <= 1'b1;
        binv_line_o  <= {tag_q[set_idx][vic_way], set_idx};
      end else if (binv_ready_i) begin
        binv_valid_o <= 1'b0;
      end
      wb_valid_o <= wb_fire;
      if (wb_fire) wb_line_o <= req_line_i;
    end
  end

  assign req_ready_o = !binv_valid_o;
endmodule

// File: rtl/ric_llc_ctrl_chk.sv
module ric_llc_ctrl_chk #(
  parameter int unsigned LINE_W = 20,
  parameter int unsigned CORE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_op_i,
  input logic [CORE_W-1:0] req_core_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic [CORE_W-1:0] resp_core_o,
  input logic              binv_valid_o,
  input logic              binv_ready_i,
  input logic [LINE_W-1:0] binv_line_o,
  input logic              wb_valid_o
);
  logic acc_lookup, acc_flush;
  assign acc_lookup = req_valid_i && req_ready_o && !req_op_i;
  assign acc_flush  = req_valid_i && req_ready_o && req_op_i;

  assert_resp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_lookup |=> resp_valid_o && (resp_core_o == $past(req_core_i)));

  assert_resp_only_lookup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_lookup |=> !resp_valid_o);

  assert_binv_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (binv_valid_o && !binv_ready_i) |=> binv_valid_o && $stable(binv_line_o));

  assert_binv_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (binv_valid_o && binv_ready_i) |=> !binv_valid_o);

  assert_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binv_valid_o |-> !req_ready_o);

  assert_binv_only_on_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_lookup |=> !(resp_hit_o && binv_valid_o));

  assert_flush_no_binv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_flush |=> !binv_valid_o);

  assert_wb_only_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_flush |=> !wb_valid_o);
endmodule

bind ric_llc_ctrl ric_llc_ctrl_chk #(.LINE_W(LINE_W), .CORE_W(CORE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_op_i(req_op_i), .req_core_i(req_core_i), .resp_valid_o(resp_valid_o),
  .resp_hit_o(resp_hit_o), .resp_core_o(resp_core_o), .binv_valid_o(binv_valid_o),
  .binv_ready_i(binv_ready_i), .binv_line_o(binv_line_o), .wb_valid_o(wb_valid_o)
);

// File: tb/ric_llc_ctrl_tb.sv
`timescale 1ns/1ps
module ric_llc_ctrl_tb;
  localparam int SETS = 16, WAYS = 16, LINE_W = 20, SET_W = 4, CORE_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, req_rel = 1'b0, binv_ready = 1'b1;
  logic [LINE_W-1:0] req_line = '0;
  logic [CORE_W-1:0] req_core = '0;
  logic req_ready_o, resp_valid_o, resp_hit_o, binv_valid_o, wb_valid_o;
  logic [CORE_W-1:0] resp_core_o;
  logic [LINE_W-1:0] binv_line_o, wb_line_o;

  always #2.5 clk = ~clk;

  ric_llc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_op_i(req_op), .req_line_i(req_line), .req_core_i(req_core), .req_relaxed_i(req_rel),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_core_o(resp_core_o),
    .binv_valid_o(binv_valid_o), .binv_ready_i(binv_ready), .binv_line_o(binv_line_o),
    .wb_valid_o(wb_valid_o), .wb_line_o(wb_line_o)
  );

  int n_tests = 0, n_fail = 0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference: per set a recency list, most recent first
  typedef struct packed { logic [15:0] tag; logic rel; } ent_t;
  ent_t mq [SETS][$];

  bit exp_resp_v, exp_hit, exp_binv_v, exp_wb_v;
  logic [CORE_W-1:0] exp_core;
  logic [LINE_W-1:0] exp_binv_line, exp_wb_line;
  logic [LINE_W-1:0] binv_log [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_resp_v = 0; exp_binv_v = 0; exp_wb_v = 0; exp_hit = 0;
      for (int s = 0; s < SETS; s++) mq[s].delete();
    end else begin
      bit acc;
      int s, idx;
      logic [15:0] t;
      ent_t e;
      if (binv_valid_o && binv_ready) binv_log.push_back(binv_line_o);
      acc = req_valid && !exp_binv_v;
      if (exp_binv_v && binv_ready) exp_binv_v = 0;
      exp_resp_v = 0;
      exp_wb_v = 0;
      if (acc) begin
        s = int'(req_line[SET_W-1:0]);
        t = req_line[LINE_W-1:SET_W];
        idx = -1;
        for (int i = 0; i < mq[s].size(); i++) if (mq[s][i].tag == t) idx = i;
        if (!req_op) begin
          exp_resp_v = 1; exp_core = req_core; exp_hit = (idx >= 0);
          if (idx >= 0) begin
            e = mq[s][idx]; mq[s].delete(idx); mq[s].push_front(e);
          end else begin
            if (mq[s].size() == WAYS) begin
              e = mq[s].pop_back();
              if (!e.rel) begin exp_binv_v = 1; exp_binv_line = {e.tag, req_line[SET_W-1:0]}; end
            end
            e.tag = t; e.rel = req_rel;
            mq[s].push_front(e);
          end
        end else if (idx >= 0) begin
          if (mq[s][idx].rel) begin exp_wb_v = 1; exp_wb_line = req_line; end
          mq[s].delete(idx);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready_o == !exp_binv_v, "R8 ready", req_ready_o, !exp_binv_v);
      check(resp_valid_o == exp_resp_v, "R2 resp_valid", resp_valid_o, exp_resp_v);
      if (exp_resp_v) begin
        check(resp_hit_o == exp_hit, "R2 hit", resp_hit_o, exp_hit);
        check(resp_core_o == exp_core, "R2 core", resp_core_o, exp_core);
      end
      check(binv_valid_o == exp_binv_v, "R6/R7 binv_valid", binv_valid_o, exp_binv_v);
      if (exp_binv_v) check(binv_line_o == exp_binv_line, "R6 binv_line", binv_line_o, exp_binv_line);
      check(wb_valid_o == exp_wb_v, "R10 wb_valid", wb_valid_o, exp_wb_v);
      if (exp_wb_v) check(wb_line_o == exp_wb_line, "R10 wb_line", wb_line_o, exp_wb_line);
    end
  end

  task automatic op(bit fl, logic [15:0] tag, logic [3:0] set, logic [1:0] core, bit rel);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1; req_op = fl; req_line = {tag, set}; req_core = core; req_rel = rel;
    @(negedge clk);
    req_valid = 0;
  endtask

  bit rnd_ready = 0;
  always @(negedge clk) if (rnd_ready) binv_ready = ($urandom_range(0, 2) != 0);

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!resp_valid_o && !binv_valid_o && !wb_valid_o && req_ready_o, "R1 idle", resp_valid_o, 0);

    op(0, 16'h0abc, 4'd2, 2'd3, 0);
    check(resp_valid_o && !resp_hit_o, "R1 first miss", resp_hit_o, 0);
    op(0, 16'h0abc, 4'd2, 2'd1, 0);
    check(resp_hit_o == 1, "R3 filled line hits", resp_hit_o, 1);
    check(resp_core_o == 2'd1, "R2 core echo", resp_core_o, 1);

    // fill set 5: tags 100..115, odd ones relaxed
    for (int i = 0; i < WAYS; i++) op(0, 16'(100 + i), 4'd5, 2'(i), i[0]);
    check(binv_log.size() == 0, "R4 no binv on free ways", binv_log.size(), 0);
    // make tag 100 most recent with a contradicting attribute
    op(0, 16'd100, 4'd5, 2'd0, 1);
    check(resp_hit_o == 1, "R5 touch hit", resp_hit_o, 1);

    binv_ready = 0;
    for (int i = 0; i < WAYS; i++) begin
      op(0, 16'(200 + i), 4'd5, 2'(i), i[0]);
      if (i == 1) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check(binv_valid_o && !req_ready_o, "R8 hold", binv_valid_o, 1);
          check(binv_line_o == {16'd102, 4'd5}, "R8 line stable", binv_line_o, {16'd102, 4'd5});
        end
        binv_ready = 1;
      end
    end
    @(negedge clk);
    check(binv_log.size() == 8, "R7 only normal victims", binv_log.size(), 8);
    if (binv_log.size() == 8) begin
      check(binv_log[0] == {16'd102, 4'd5}, "R5 LRU order", binv_log[0], {16'd102, 4'd5});
      check(binv_log[7] == {16'd100, 4'd5}, "R9 hit kept normal flag", binv_log[7], {16'd100, 4'd5});
    end

    op(1, 16'd201, 4'd5, 2'd0, 0);
    check(wb_valid_o && wb_line_o == {16'd201, 4'd5}, "R3 relaxed latched", wb_line_o, {16'd201, 4'd5});
    check(wb_valid_o == 1, "R10 wb pulse", wb_valid_o, 1);
    @(negedge clk);
    check(wb_valid_o == 0, "R10 single cycle", wb_valid_o, 0);
    op(0, 16'd201, 4'd5, 2'd0, 0);
    check(resp_hit_o == 0, "R10 invalidated", resp_hit_o, 0);
    op(1, 16'd202, 4'd5, 2'd0, 0);
    check(wb_valid_o == 0, "R11 normal flush no wb", wb_valid_o, 0);
    op(0, 16'd202, 4'd5, 2'd0, 0);
    check(resp_hit_o == 0, "R11 normal invalidated", resp_hit_o, 0);
    op(1, 16'd999, 4'd5, 2'd0, 0);
    check(wb_valid_o == 0 && resp_valid_o == 0, "R11 flush miss", wb_valid_o, 0);
    op(0, 16'd204, 4'd5, 2'd0, 0);
    check(resp_hit_o == 1, "R11 other line intact", resp_hit_o, 1);

    // random mix on four sets
    rnd_ready = 1;
    for (int i = 0; i < 3000; i++)
      op($urandom_range(0, 6) == 0, 16'($urandom_range(0, 23)), 4'($urandom_range(8, 11)),
         2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
    rnd_ready = 0;
    binv_ready = 1;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule